// File: doc/BRIEF.md
# Interrupt Aggregator with Message Signalling

This block gathers a set of interrupt input lines and turns activity on them into one outbound interrupt message. Each line is first brought into the local clock domain. A rising transition on a line that is implemented and enabled is then latched into a request register. When nothing is already waiting on the message port, the block raises a single posted write on that port. The write carries a word that software has programmed into a target register. That word holds the address and data that the receiving processor's interrupt register expects.

Software handles the interrupt by reading the request register. The read returns the lines that fired and clears them in the same access. A second capture register, the pending register, records transitions on every implemented line whatever the enable mask holds, and it is also cleared when read. A live level register shows the synchronised state of the inputs and is never cleared. After unmasking a line, software can check the level register to find a line that is still asserted, and so treat an edge-signalled source as if it were level-sensitive.

The default configuration has eleven line positions, 0 to 10. Position 9 is not implemented, which gives an implemented-line mask of 0x5FF. Registers are reached through a simple strobe bus with a registered read port.

Top module: `irq_agg`

## Requirements
- R1: After reset, the request, pending, enable mask and target registers all read 0, `msg_valid` is low and `reg_rdata` is 0.
- R2: The level register (byte offset 0x028) returns the inputs after a two-flop synchroniser: bit i is 1 when line i is high and implemented. It reflects an input change on the third rising clock edge after the change. Bit 9 always reads 0.
- R3: A rising transition on an implemented line whose enable bit is set sets that bit in the request register (offset 0x00C). This happens on the third clock edge after the input rises. Reading offset 0x00C returns the register and clears it. A transition captured on the same edge as the read survives the clear.
- R4: The pending register (offset 0x01C) captures rising transitions on all implemented lines, whether enabled or not, and a read of it clears it. Reading it leaves the level register unchanged.
- R5: The enable mask register (offset 0x018) is read/write with one bit per line. Bits of unimplemented lines (bit 9) cannot be set.
- R6: When an enabled transition is captured, the target register (offset 0x004) is nonzero and no message is waiting, `msg_valid` rises on that same edge. `msg_payload` then equals the target value at that edge. Both are held until `msg_ready` is sampled high, even if the target register is rewritten in the meantime.
- R7: At most one message is outstanding. Enabled transitions captured while `msg_valid` is high only merge into the request register. On the edge where `msg_ready` is sampled high with `msg_valid`, the message is retired and `msg_valid` is low on the following cycle.
- R8: While the target register is 0, no message is raised, although the request register still captures.
- R9: A line that is already high while its enable bit is clear does not set a request bit or raise a message when that bit is later set.
- R10: Transitions on the unimplemented line 9 affect neither the request register, the pending register nor the message port.
- R11: Writes to the request, pending and level offsets have no effect. A read at any offset loads `reg_rdata` on the edge where `reg_rd` is sampled; unmapped offsets return 0. `reg_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 11 | Interrupt input lines, asynchronous |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| msg_valid | output | 1 | Outbound interrupt message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_payload | output | 32 | Programmed address/data word of the message |

## Verification
The hardest case to reach from the ports is a request-register read that lands on exactly the edge where a new transition is captured. To get there, the stimulus raises a line and then places the read strobe two cycles later, so that clear and set meet on the third edge. A second hard case is an enabled transition that arrives while a message is held back by a low `msg_ready`. The bench reaches it by holding the port stalled, rewriting the target and raising a second line, and only then releasing the port. A long phase of random line toggling, random acceptance and interleaved register traffic is compared every cycle against a behavioural model built on a short input history.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // byte offsets of the register bus; software depends on these
  localparam int unsigned OFS_TARGET  = 32'h004;
  localparam int unsigned OFS_REQUEST = 32'h00C;
  localparam int unsigned OFS_ENABLE  = 32'h018;
  localparam int unsigned OFS_PENDING = 32'h01C;
  localparam int unsigned OFS_LEVEL   = 32'h028;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TARGET,
    SEL_REQUEST,
    SEL_ENABLE,
    SEL_PENDING,
    SEL_LEVEL
  } reg_sel_e;
endpackage

// File: rtl/irq_agg_sync.sv
// Two-flop synchroniser per line followed by a rising-transition detector.
module irq_agg_sync #(
  parameter int unsigned N_LINES = 11,
  parameter logic [N_LINES-1:0] IMPL_MASK = 11'h5FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] level_o,
  output logic [N_LINES-1:0] rise_o
);
  logic [N_LINES-1:0] meta_q;
  logic [N_LINES-1:0] sync_q;
  logic [N_LINES-1:0] hist_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        hist_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= lines_i[i];
        sync_q[i] <= meta_q[i];
        hist_q[i] <= sync_q[i];
      end
    end
  end

  always_comb begin
    level_o = sync_q & IMPL_MASK;
    rise_o  = sync_q & ~hist_q & IMPL_MASK;
  end
endmodule

// File: rtl/irq_agg_regs.sv
// Register file: target word, enable mask, read-clear capture registers.
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_LINES = 11,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [N_LINES-1:0] IMPL_MASK = 11'h5FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [N_LINES-1:0] rise_i,
  input  logic [N_LINES-1:0] new_req_i,
  input  logic [N_LINES-1:0] level_i,
  output logic [N_LINES-1:0] enable_o,
  output logic [DATA_W-1:0]  target_o,
  output logic [DATA_W-1:0]  rdata_o
);
  reg_sel_e           sel;
  logic               clr_req, clr_pend, wr_en, wr_tgt;
  logic [N_LINES-1:0] req_q, req_d;
  logic [N_LINES-1:0] pend_q, pend_d;
  logic [N_LINES-1:0] en_q, en_d;
  logic [DATA_W-1:0]  tgt_q, tgt_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic [DATA_W-1:0]  rd_mux;

  always_comb begin
    if (addr_i == ADDR_W'(OFS_TARGET))       sel = SEL_TARGET;
    else if (addr_i == ADDR_W'(OFS_REQUEST)) sel = SEL_REQUEST;
    else if (addr_i == ADDR_W'(OFS_ENABLE))  sel = SEL_ENABLE;
    else if (addr_i == ADDR_W'(OFS_PENDING)) sel = SEL_PENDING;
    else if (addr_i == ADDR_W'(OFS_LEVEL))   sel = SEL_LEVEL;
    else                                     sel = SEL_NONE;
  end

  always_comb begin
    clr_req  = rd_i && (sel == SEL_REQUEST);
    clr_pend = rd_i && (sel == SEL_PENDING);
    wr_en    = wr_i && (sel == SEL_ENABLE);
    wr_tgt   = wr_i && (sel == SEL_TARGET);
  end

  always_comb begin
    unique case (sel)
      SEL_TARGET:  rd_mux = tgt_q;
      SEL_REQUEST: rd_mux = DATA_W'(req_q);
      SEL_ENABLE:  rd_mux = DATA_W'(en_q);
      SEL_PENDING: rd_mux = DATA_W'(pend_q);
      SEL_LEVEL:   rd_mux = DATA_W'(level_i);
      default:     rd_mux = '0;
    endcase
  end

  // next state: a capture in the clearing cycle wins over the clear
  always_comb begin
    req_d   = (clr_req  ? '0 : req_q)  | new_req_i;
    pend_d  = (clr_pend ? '0 : pend_q) | rise_i;
    en_d    = wr_en  ? (wdata_i[N_LINES-1:0] & IMPL_MASK) : en_q;
    tgt_d   = wr_tgt ? wdata_i : tgt_q;
    rdata_d = rd_i   ? rd_mux  : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      pend_q  <= '0;
      en_q    <= '0;
      tgt_q   <= '0;
      rdata_q <= '0;
    end else begin
      req_q   <= req_d;
      pend_q  <= pend_d;
      en_q    <= en_d;
      tgt_q   <= tgt_d;
      rdata_q <= rdata_d;
    end
  end

  assign enable_o = en_q;
  assign target_o = tgt_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/irq_agg_msg.sv
// Single-entry posted message generator.
module irq_agg_msg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger_i,
  input  logic [DATA_W-1:0] target_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] payload_o
);
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] pay_q, pay_d;
  logic              launch, retire;

  always_comb begin
    launch = trigger_i && (target_i != '0) && !valid_q;
    retire = valid_q && ready_i;
    if (launch)      valid_d = 1'b1;
    else if (retire) valid_d = 1'b0;
    else             valid_d = valid_q;
    pay_d = launch ? target_i : pay_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pay_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (launch) pay_q <= pay_d;
    end
  end

  assign valid_o   = valid_q;
  assign payload_o = pay_q;
endmodule

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int unsigned N_LINES = 11,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [N_LINES-1:0] IMPL_MASK = 11'h5FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [DATA_W-1:0]  msg_payload
);
  logic [N_LINES-1:0] level_w, rise_w, enable_w, new_req_w;
  logic [DATA_W-1:0]  target_w;

  irq_agg_sync #(.N_LINES(N_LINES), .IMPL_MASK(IMPL_MASK)) u_sync (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_in),
    .level_o(level_w), .rise_o(rise_w)
  );

  assign new_req_w = rise_w & enable_w;

  irq_agg_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                 .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_i(reg_rd), .wr_i(reg_wr),
    .addr_i(reg_addr), .wdata_i(reg_wdata), .rise_i(rise_w),
    .new_req_i(new_req_w), .level_i(level_w), .enable_o(enable_w),
    .target_o(target_w), .rdata_o(reg_rdata)
  );

  irq_agg_msg #(.DATA_W(DATA_W)) u_msg (
    .clk(clk), .rst_n(rst_n), .trigger_i(|new_req_w), .target_i(target_w),
    .ready_i(msg_ready), .valid_o(msg_valid), .payload_o(msg_payload)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned N_LINES = 11,
  parameter int unsigned DATA_W  = 32,
  parameter logic [N_LINES-1:0] IMPL_MASK = 11'h5FF
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [DATA_W-1:0]  msg_payload,
  input logic               reg_rd,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [N_LINES-1:0] enable_w
);
  assert_msg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_payload)));

  assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);

  assert_no_zero_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_payload != '0));

  assert_enable_impl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_w & ~IMPL_MASK) == '0);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind irq_agg irq_agg_chk #(.N_LINES(N_LINES), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_payload(msg_payload), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .enable_w(enable_w)
);

// File: tb/irq_agg_tb.sv
`timescale 1ns/1ps
module irq_agg_tb;
  localparam int N = 11;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam logic [N-1:0] IMPL = 11'h5FF;
  localparam logic [AW-1:0] A_TGT = 12'h004, A_REQ = 12'h00C, A_EN = 12'h018,
                            A_PEND = 12'h01C, A_LVL = 12'h028;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]  irq = '0;
  logic          rd = 1'b0, wr = 1'b0, ready = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, payload;
  logic          valid;

  irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .reg_rd(rd), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .msg_valid(valid), .msg_ready(ready), .msg_payload(payload)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [N-1:0]  h1, h2, h3;   // input samples 1, 2, 3 edges ago
  logic [N-1:0]  m_en, m_req, m_pend, rise, newr;
  logic [DW-1:0] m_tgt, m_rdata, m_pay;
  logic          m_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0; m_en = '0; m_req = '0; m_pend = '0;
      m_tgt = '0; m_rdata = '0; m_pay = '0; m_valid = 1'b0;
    end else begin
      rise = h2 & ~h3 & IMPL;
      newr = rise & m_en;
      if (rd) begin
        case (addr)
          A_TGT:   m_rdata = m_tgt;
          A_REQ:   m_rdata = DW'(m_req);
          A_EN:    m_rdata = DW'(m_en);
          A_PEND:  m_rdata = DW'(m_pend);
          A_LVL:   m_rdata = DW'(h2 & IMPL);
          default: m_rdata = '0;
        endcase
      end
      if (newr != 0 && m_tgt != 0 && !m_valid) begin
        m_valid = 1'b1;
        m_pay = m_tgt;
      end else if (m_valid && ready) begin
        m_valid = 1'b0;
      end
      m_req  = ((rd && addr == A_REQ)  ? '0 : m_req)  | newr;
      m_pend = ((rd && addr == A_PEND) ? '0 : m_pend) | rise;
      if (wr && addr == A_EN)  m_en = wdata[N-1:0] & IMPL;
      if (wr && addr == A_TGT) m_tgt = wdata;
      h3 = h2; h2 = h1; h1 = irq;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R6/R7 per-cycle msg_valid", DW'(valid), DW'(m_valid));
      if (m_valid) chk("R6 per-cycle msg_payload", payload, m_pay);
      chk("R11 per-cycle reg_rdata", rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 msg_valid after reset", DW'(valid), 0);
    chk("R1 rdata after reset", rdata, 0);
    rd_chk(A_REQ,  0, "R1 request reset");
    rd_chk(A_PEND, 0, "R1 pending reset");
    rd_chk(A_EN,   0, "R1 enable reset");
    rd_chk(A_TGT,  0, "R1 target reset");

    // R5 enable mask, bit 9 cannot be set
    wr_reg(A_EN, 32'h7FF);
    rd_chk(A_EN, 32'h5FF, "R5 enable readback");

    // R2/R3/R4/R8: all lines rise with target zero
    @(negedge clk); irq = 11'h7FF;
    idle(4);
    chk("R8 no message with zero target", DW'(valid), 0);
    rd_chk(A_LVL,  32'h5FF, "R2 level all high bit9 hidden");
    rd_chk(A_REQ,  32'h5FF, "R3 request captured");
    rd_chk(A_REQ,  32'h000, "R3 request cleared by read");
    rd_chk(A_PEND, 32'h5FF, "R4 pending captured");
    rd_chk(A_PEND, 32'h000, "R4 pending cleared by read");
    rd_chk(A_LVL,  32'h5FF, "R4 level unchanged by pending read");
    @(negedge clk); irq = '0;
    idle(5);

    // R6 message with stalled port, R7 merge
    wr_reg(A_EN, 32'h001);
    wr_reg(A_TGT, 32'hABCD_0040);
    @(negedge clk); irq[0] = 1'b1;
    idle(5);
    chk("R6 msg_valid raised", DW'(valid), 1);
    chk("R6 payload equals target", payload, 32'hABCD_0040);
    wr_reg(A_TGT, 32'h0000_1234);
    wr_reg(A_EN, 32'h003);
    @(negedge clk); irq[1] = 1'b1;
    idle(5);
    chk("R6 payload held after target rewrite", payload, 32'hABCD_0040);
    chk("R7 still one message outstanding", DW'(valid), 1);
    @(negedge clk); ready = 1'b1;
    @(negedge clk);
    chk("R7 retired after accept", DW'(valid), 0);
    idle(4);
    chk("R7 no second message for merged edge", DW'(valid), 0);
    rd_chk(A_REQ,  32'h003, "R7 merged request bits");
    rd_chk(A_PEND, 32'h003, "R4 pending after merge");

    // R9 line high while masked, then unmasked
    wr_reg(A_EN, 32'h000);
    @(negedge clk); irq[2] = 1'b1;
    idle(5);
    wr_reg(A_EN, 32'h004);
    idle(5);
    chk("R9 no message on unmask", DW'(valid), 0);
    rd_chk(A_REQ,  32'h000, "R9 no request on unmask");
    rd_chk(A_PEND, 32'h004, "R4 pending captures masked line");
    rd_chk(A_LVL,  32'h007, "R4 level shows asserted lines");

    // R10 unimplemented line
    wr_reg(A_EN, 32'h7FF);
    rd_chk(A_EN, 32'h5FF, "R5 bit9 not writable");
    @(negedge clk); irq[9] = 1'b1;
    idle(5);
    chk("R10 no message for line 9", DW'(valid), 0);
    rd_chk(A_REQ,  32'h000, "R10 request ignores line 9");
    rd_chk(A_PEND, 32'h000, "R10 pending ignores line 9");
    rd_chk(A_LVL,  32'h007, "R2 level hides line 9");

    // R11 read-only offsets and registered read data
    wr_reg(A_REQ,  32'h7FF);
    wr_reg(A_PEND, 32'h7FF);
    wr_reg(A_LVL,  32'h7FF);
    rd_chk(A_REQ,  32'h000, "R11 write to request ignored");
    rd_chk(A_PEND, 32'h000, "R11 write to pending ignored");
    rd_chk(A_LVL,  32'h007, "R11 write to level ignored");
    rd_chk(12'h100, 32'h000, "R11 unmapped offset reads zero");
    rd_chk(A_TGT, 32'h0000_1234, "R11 target readback");
    idle(3);
    chk("R11 rdata held between reads", rdata, 32'h0000_1234);

    // R3 read on the same edge as a capture
    @(negedge clk); irq[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); rd = 1'b1; addr = A_REQ;
    @(negedge clk); rd = 1'b0;
    chk("R3 read at capture edge returns old", rdata, 32'h000);
    rd_chk(A_REQ, 32'h008, "R3 capture survives same-edge clear");

    // random phase, compared every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd = 1'b0; wr = 1'b0;
      if ($urandom_range(0, 5) == 0) irq = irq ^ N'($urandom);
      ready = ($urandom_range(0, 2) != 0);
      case ($urandom_range(0, 9))
        0: begin rd = 1'b1; addr = A_REQ; end
        1: begin rd = 1'b1; addr = A_PEND; end
        2: begin rd = 1'b1; addr = A_LVL; end
        3: begin wr = 1'b1; addr = A_EN; wdata = $urandom; end
        4: begin wr = 1'b1; addr = A_TGT;
                 wdata = ($urandom_range(0, 3) == 0) ? '0 : $urandom; end
        5: begin rd = 1'b1; addr = A_TGT; end
        default: ;
      endcase
    end
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    idle(4);
    finish_run();
  end
endmodule